// File: doc/BRIEF.md
# Thread Event and Interrupt Sequencer

This block keeps the status flags of one hardware thread together with a shadow copy of its program counter, status and event data. Every clock cycle it decides whether an event or an interrupt offered by the thread's resources is accepted. It also carries out four status instructions: wait-for-event, set bits, clear bits and kernel return. When it redirects the thread, it presents the new program counter one cycle later with a redirect strobe.

The two kinds of request work differently. An event sends the thread to its vector and saves nothing. An interrupt first copies the current program counter, status and event data into the shadow registers and then forces kernel mode. Kernel return copies the shadow state back. A thread that was suspended in a wait before the interrupt is therefore suspended again after the return.

Top module: `tec_thread_ctrl`

## Requirements
- R1: After reset the status, event data and all shadow registers are zero, `pc_redirect` is 0 and `next_pc` equals the `RESET_PC` parameter (default 0x40). A kernel return issued straight after reset redirects to 0 and restores a zero status.
- R2: Status bit positions: bit 0 event enable, bit 1 interrupt enable, bit 2 enabling-events, bit 3 in-interrupt, bit 4 kernel mode, bit 5 saved kernel mode, bit 6 waiting, bit 7 fast mode.
- R3: An interrupt is accepted in a cycle where `irq_rdy` is high and the registered interrupt-enable bit is 1. On the next edge the block saves `cur_pc`, the status and the event data into the shadow registers, loads `evt_data` from `irq_env`, sets `next_pc` to `irq_vec` and raises `pc_redirect` for one cycle.
- R4: On interrupt acceptance the in-interrupt and kernel bits are set and the event-enable, interrupt-enable and waiting bits are cleared in one step. The other bits keep their value.
- R5: An event is accepted when `evt_rdy` is high, the event-enable bit is 1 and no interrupt is accepted. It redirects to `evt_vec`, loads `evt_data` from `evt_env` and clears the waiting bit. It leaves the shadow registers unchanged.
- R6: When both requests are ready and enabled in the same cycle, the interrupt is accepted and the event is not.
- R7: `op_wait` sets the event-enable and waiting bits.
- R8: `op_setsr` sets and `op_clrsr` clears only the status bits that are 1 in `op_mask`. No other bit changes.
- R9: Enabling a request that is already pending makes it accepted in the very next cycle.
- R10: `op_kret` restores the status and event data from the shadow registers and redirects to the saved program counter.
- R11: `suspend` is high exactly when the waiting bit is 1 and no enabled request is ready in the current cycle.
- R12: In a cycle where a request is accepted, all instruction strobes are ignored. Among the strobes, kernel return has the highest priority, then wait, then set, then clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_rdy | input | 1 | Event ready from a resource |
| evt_vec | input | PC_W | Event vector |
| evt_env | input | ED_W | Event environment value |
| irq_rdy | input | 1 | Interrupt ready from a resource |
| irq_vec | input | PC_W | Interrupt vector |
| irq_env | input | ED_W | Interrupt environment value |
| op_wait | input | 1 | Wait-for-event strobe |
| op_setsr | input | 1 | Set-status-bits strobe |
| op_clrsr | input | 1 | Clear-status-bits strobe |
| op_kret | input | 1 | Kernel return strobe |
| op_mask | input | 8 | Bit mask for set and clear |
| cur_pc | input | PC_W | Program counter of the current instruction |
| next_pc | output | PC_W | Redirect target |
| pc_redirect | output | 1 | One-cycle strobe: `next_pc` is valid |
| status | output | 8 | Live status register |
| evt_data | output | ED_W | Event-data register |
| suspend | output | 1 | Thread is suspended |

## Verification
A wrong shadow register stays invisible until the next kernel return. That return then shows it on `next_pc`, `status` and `evt_data` one cycle after the strobe. For this reason the bench pairs every interrupt and every event with a later return. A bad priority or enable decision shows on `next_pc` and `pc_redirect` one edge after the request. A wrong suspend term shows in the same cycle, while the ready lines are still being driven.

// File: rtl/tec_pkg.sv
package tec_pkg;
  localparam int SR_W = 8;

  localparam int B_EVEN  = 0;
  localparam int B_IREN  = 1;
  localparam int B_ENBG  = 2;
  localparam int B_INIRQ = 3;
  localparam int B_KMODE = 4;
  localparam int B_SKMOD = 5;
  localparam int B_WAIT  = 6;
  localparam int B_FAST  = 7;

  typedef logic [SR_W-1:0] sr_t;

  function automatic sr_t bitmask(input int pos);
    sr_t m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction

  function automatic sr_t irq_entry_sr(input sr_t s);
    sr_t clr_m, set_m;
    clr_m = bitmask(B_EVEN) | bitmask(B_IREN) | bitmask(B_WAIT);
    set_m = bitmask(B_INIRQ) | bitmask(B_KMODE);
    return (s & ~clr_m) | set_m;
  endfunction

  function automatic sr_t evt_entry_sr(input sr_t s);
    return s & ~bitmask(B_WAIT);
  endfunction

  function automatic sr_t wait_sr(input sr_t s);
    return s | bitmask(B_EVEN) | bitmask(B_WAIT);
  endfunction

  function automatic sr_t masked_update(input sr_t s, input sr_t m, input logic set);
    return set ? (s | m) : (s & ~m);
  endfunction
endpackage

// File: rtl/tec_arbiter.sv
module tec_arbiter
  import tec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sr_t  sr_q,
  input  logic evt_rdy,
  input  logic irq_rdy,
  input  logic op_wait,
  input  logic op_setsr,
  input  logic op_clrsr,
  input  logic op_kret,
  output logic take_irq,
  output logic take_evt,
  output logic do_kret,
  output logic do_wait,
  output logic do_set,
  output logic do_clr,
  output logic suspend
);
  logic irq_live, evt_live, any_take;

  always_comb begin
    irq_live = irq_rdy & sr_q[B_IREN];
    evt_live = evt_rdy & sr_q[B_EVEN];
    take_irq = irq_live;
    take_evt = evt_live & ~irq_live;
    any_take = take_irq | take_evt;
    do_kret  = ~any_take & op_kret;
    do_wait  = ~any_take & ~op_kret & op_wait;
    do_set   = ~any_take & ~op_kret & ~op_wait & op_setsr;
    do_clr   = ~any_take & ~op_kret & ~op_wait & ~op_setsr & op_clrsr;
    suspend  = sr_q[B_WAIT] & ~irq_live & ~evt_live;
  end

  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_irq && take_evt)); // R6
  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_irq, take_evt, do_kret, do_wait, do_set, do_clr})); // R12
  AST_SUSP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> (sr_q[B_WAIT] && !take_irq && !take_evt)); // R11
endmodule

// File: rtl/tec_status.sv
module tec_status
  import tec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_irq,
  input  logic take_evt,
  input  logic do_kret,
  input  logic do_wait,
  input  logic do_set,
  input  logic do_clr,
  input  sr_t  mask,
  input  sr_t  saved_sr,
  output sr_t  sr_q
);
  sr_t sr_d;

  always_comb begin
    sr_d = sr_q;
    if (take_irq)      sr_d = irq_entry_sr(sr_q);
    else if (take_evt) sr_d = evt_entry_sr(sr_q);
    else if (do_kret)  sr_d = saved_sr;
    else if (do_wait)  sr_d = wait_sr(sr_q);
    else if (do_set)   sr_d = masked_update(sr_q, mask, 1'b1);
    else if (do_clr)   sr_d = masked_update(sr_q, mask, 1'b0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  AST_IRQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> (sr_q[B_INIRQ] && sr_q[B_KMODE] && !sr_q[B_EVEN] && !sr_q[B_IREN] && !sr_q[B_WAIT])); // R4
  AST_SET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    do_set |=> (((sr_q ^ $past(sr_q)) & ~$past(mask)) == '0)); // R8
  AST_CLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> (((sr_q ^ $past(sr_q)) & ~$past(mask)) == '0)); // R8
  AST_WAIT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    do_wait |=> (sr_q[B_EVEN] && sr_q[B_WAIT])); // R7
  AST_EVT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> !sr_q[B_WAIT]); // R5
endmodule

// File: rtl/tec_shadow.sv
module tec_shadow
  import tec_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int ED_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [PC_W-1:0] pc_in,
  input  sr_t             sr_in,
  input  logic [ED_W-1:0] ed_in,
  output logic [PC_W-1:0] spc_q,
  output sr_t             ssr_q,
  output logic [ED_W-1:0] sed_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spc_q <= '0;
      ssr_q <= '0;
      sed_q <= '0;
    end else if (capture) begin
      spc_q <= pc_in;
      ssr_q <= sr_in;
      sed_q <= ed_in;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(spc_q) && $stable(ssr_q) && $stable(sed_q))); // R5
endmodule

// File: rtl/tec_thread_ctrl.sv
module tec_thread_ctrl
  import tec_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              ED_W     = 16,
  parameter logic [PC_W-1:0] RESET_PC = 32'h0000_0040
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_rdy,
  input  logic [PC_W-1:0] evt_vec,
  input  logic [ED_W-1:0] evt_env,
  input  logic            irq_rdy,
  input  logic [PC_W-1:0] irq_vec,
  input  logic [ED_W-1:0] irq_env,
  input  logic            op_wait,
  input  logic            op_setsr,
  input  logic            op_clrsr,
  input  logic            op_kret,
  input  logic [7:0]      op_mask,
  input  logic [PC_W-1:0] cur_pc,
  output logic [PC_W-1:0] next_pc,
  output logic            pc_redirect,
  output logic [7:0]      status,
  output logic [ED_W-1:0] evt_data,
  output logic            suspend
);
  sr_t             sr_q, ssr_q;
  logic [PC_W-1:0] spc_q;
  logic [ED_W-1:0] sed_q, ed_q;
  logic take_irq, take_evt, do_kret, do_wait, do_set, do_clr;

  tec_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .sr_q(sr_q),
    .evt_rdy(evt_rdy), .irq_rdy(irq_rdy),
    .op_wait(op_wait), .op_setsr(op_setsr), .op_clrsr(op_clrsr), .op_kret(op_kret),
    .take_irq(take_irq), .take_evt(take_evt), .do_kret(do_kret),
    .do_wait(do_wait), .do_set(do_set), .do_clr(do_clr), .suspend(suspend)
  );

  tec_status u_sr (
    .clk(clk), .rst_n(rst_n), .take_irq(take_irq), .take_evt(take_evt),
    .do_kret(do_kret), .do_wait(do_wait), .do_set(do_set), .do_clr(do_clr),
    .mask(op_mask), .saved_sr(ssr_q), .sr_q(sr_q)
  );

  tec_shadow #(.PC_W(PC_W), .ED_W(ED_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .capture(take_irq),
    .pc_in(cur_pc), .sr_in(sr_q), .ed_in(ed_q),
    .spc_q(spc_q), .ssr_q(ssr_q), .sed_q(sed_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ed_q        <= '0;
      next_pc     <= RESET_PC;
      pc_redirect <= 1'b0;
    end else begin
      pc_redirect <= take_irq | take_evt | do_kret;
      if (take_irq) begin
        ed_q    <= irq_env;
        next_pc <= irq_vec;
      end else if (take_evt) begin
        ed_q    <= evt_env;
        next_pc <= evt_vec;
      end else if (do_kret) begin
        ed_q    <= sed_q;
        next_pc <= spc_q;
      end
    end
  end

  assign status   = sr_q;
  assign evt_data = ed_q;

  AST_IRQ_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> (spc_q == $past(cur_pc) && ssr_q == $past(sr_q) && sed_q == $past(ed_q))); // R3
  AST_IRQ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rdy && sr_q[B_IREN]) |=> (pc_redirect && next_pc == $past(irq_vec) && ed_q == $past(irq_env))); // R6
  AST_EVT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> (pc_redirect && next_pc == $past(evt_vec) && ed_q == $past(evt_env))); // R5
  AST_KRET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    do_kret |=> (next_pc == $past(spc_q) && sr_q == $past(ssr_q) && ed_q == $past(sed_q))); // R10
  AST_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_irq || take_evt || do_kret) |=> (!pc_redirect && $stable(next_pc))); // R12
endmodule

// File: tb/tb_tec_thread_ctrl.sv
module tb_tec_thread_ctrl;
  localparam int PC_W = 32;
  localparam int ED_W = 16;
  localparam logic [31:0] EV = 32'h100, IV = 32'h200;
  localparam logic [15:0] EENV = 16'h00E1, IENV = 16'h00A5;
  localparam int NV = 20;
  // {op[3:0] kret,wait,set,clr; mask; evt; irq; pc16} {redir; pc16; sr; ed16; susp}
  localparam logic [71:0] TBL [NV] = '{
    {4'h0, 8'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0040, 8'h00, 16'h0000, 1'b0},
    {4'h0, 8'h00, 1'b0, 1'b1, 16'h0000, 1'b0, 16'h0040, 8'h00, 16'h0000, 1'b0},
    {4'h2, 8'h80, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0040, 8'h80, 16'h0000, 1'b0},
    {4'h2, 8'h02, 1'b0, 1'b1, 16'h0000, 1'b0, 16'h0040, 8'h82, 16'h0000, 1'b0},
    {4'h0, 8'h00, 1'b0, 1'b1, 16'h1234, 1'b1, 16'h0200, 8'h98, 16'h00A5, 1'b0},
    {4'h8, 8'h00, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h1234, 8'h82, 16'h0000, 1'b0},
    {4'h1, 8'h80, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h1234, 8'h02, 16'h0000, 1'b0},
    {4'h4, 8'h00, 1'b0, 1'b0, 16'h0050, 1'b0, 16'h1234, 8'h43, 16'h0000, 1'b1},
    {4'h0, 8'h00, 1'b0, 1'b0, 16'h0050, 1'b0, 16'h1234, 8'h43, 16'h0000, 1'b1},
    {4'h0, 8'h00, 1'b0, 1'b1, 16'h0050, 1'b1, 16'h0200, 8'h18, 16'h00A5, 1'b0},
    {4'h0, 8'h00, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0200, 8'h18, 16'h00A5, 1'b0},
    {4'h8, 8'h00, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0050, 8'h43, 16'h0000, 1'b1},
    {4'h0, 8'h00, 1'b1, 1'b1, 16'h0050, 1'b1, 16'h0200, 8'h18, 16'h00A5, 1'b0},
    {4'h8, 8'h00, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0050, 8'h43, 16'h0000, 1'b1},
    {4'h0, 8'h00, 1'b1, 1'b0, 16'h0050, 1'b1, 16'h0100, 8'h03, 16'h00E1, 1'b0},
    {4'h8, 8'h00, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0050, 8'h43, 16'h0000, 1'b1},
    {4'h1, 8'h41, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h0100, 8'h03, 16'h00E1, 1'b0},
    {4'h1, 8'h03, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0100, 8'h00, 16'h00E1, 1'b0},
    {4'h2, 8'h01, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0100, 8'h01, 16'h00E1, 1'b0},
    {4'h0, 8'h00, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h0100, 8'h01, 16'h00E1, 1'b0}
  };
  localparam string TAGS [NV] = '{"R2", "R3", "R8", "R9", "R3 R4", "R10", "R8", "R7 R11",
    "R11", "R3 R4", "R5", "R10", "R6", "R10", "R5", "R5 R10", "R12", "R8", "R9", "R9"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_rdy = 1'b0, irq_rdy = 1'b0;
  logic op_wait = 1'b0, op_setsr = 1'b0, op_clrsr = 1'b0, op_kret = 1'b0;
  logic [7:0] op_mask = '0;
  logic [PC_W-1:0] cur_pc = '0, next_pc;
  logic pc_redirect, suspend;
  logic [7:0] status;
  logic [ED_W-1:0] evt_data;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  tec_thread_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_rdy(evt_rdy), .evt_vec(EV), .evt_env(EENV),
    .irq_rdy(irq_rdy), .irq_vec(IV), .irq_env(IENV),
    .op_wait(op_wait), .op_setsr(op_setsr), .op_clrsr(op_clrsr), .op_kret(op_kret),
    .op_mask(op_mask), .cur_pc(cur_pc), .next_pc(next_pc), .pc_redirect(pc_redirect),
    .status(status), .evt_data(evt_data), .suspend(suspend)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    {evt_rdy, irq_rdy, op_kret, op_wait, op_setsr, op_clrsr} = '0;
    op_mask = '0;
    cur_pc = '0;
  endtask

  task automatic drive(input logic [3:0] op, input logic [7:0] m, input logic e,
                       input logic i, input logic [15:0] pc);
    {op_kret, op_wait, op_setsr, op_clrsr} = op;
    op_mask = m;
    evt_rdy = e;
    irq_rdy = i;
    cur_pc = {16'h0, pc};
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 status", {56'h0, status}, 64'h0);
    check("R1 evt_data", {48'h0, evt_data}, 64'h0);
    check("R1 next_pc", {32'h0, next_pc}, 64'h40);
    check("R1 redirect", {63'h0, pc_redirect}, 64'h0);
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(TBL[k][71:68], TBL[k][67:60], TBL[k][59], TBL[k][58], TBL[k][57:42]);
      @(posedge clk);
      #1 idle();
      #1;
      check({TAGS[k], " redirect"}, {63'h0, pc_redirect}, {63'h0, TBL[k][41]});
      check({TAGS[k], " next_pc"}, {32'h0, next_pc}, {48'h0, TBL[k][40:25]});
      check({TAGS[k], " status"}, {56'h0, status}, {56'h0, TBL[k][24:17]});
      check({TAGS[k], " evt_data"}, {48'h0, evt_data}, {48'h0, TBL[k][16:1]});
      check({TAGS[k], " suspend"}, {63'h0, suspend}, {63'h0, TBL[k][0]});
    end
    // R11: the suspend flag follows the ready lines in the same cycle
    @(negedge clk);
    drive(4'h1, 8'hFF, 1'b0, 1'b0, 16'h0);
    @(negedge clk);
    drive(4'h4, 8'h00, 1'b0, 1'b0, 16'h0060);
    @(negedge clk);
    idle();
    #1 check("R11 waiting idle", {63'h0, suspend}, 64'h1);
    evt_rdy = 1'b1;
    #1 check("R11 enabled event pending", {63'h0, suspend}, 64'h0);
    evt_rdy = 1'b0;
    irq_rdy = 1'b1;
    #1 check("R11 disabled irq pending", {63'h0, suspend}, 64'h1);
    irq_rdy = 1'b0;
    // R1: the shadow registers are cleared by reset, shown by a kernel return
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(4'h8, 8'h00, 1'b0, 1'b0, 16'h0);
    @(posedge clk);
    #1 idle();
    #1 check("R1 shadow pc", {32'h0, next_pc}, 64'h0);
    check("R1 shadow sr", {56'h0, status}, 64'h0);
    check("R1 shadow ed", {48'h0, evt_data}, 64'h0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule